// File: doc/BRIEF.md
# Sign-Symmetric Iterative Integer Divider

This block divides two's complement integers of byte, halfword, word or long size held in 64-bit registers. The caller raises `start` for one cycle with a size code, a dividend on `src_val` and a divisor on `dst_val`. The block raises `busy` and computes one quotient bit per cycle on the operand magnitudes. It then pulses `done` with the quotient and the remainder, both sign-extended to 64 bits, and a divide-by-zero flag.

Signs are applied after the magnitude division. The quotient and the remainder always carry the same sign. Both are zero or positive when the operands agree in sign, and both are zero or negative when they differ. Only the low bits of each operand that the size code selects take part. Results hold on the outputs until the next operation completes.

Top module: `sdiv_unit`

## Requirements
- R1: The value on `src_val` is the dividend and the value on `dst_val` is the divisor. The quotient magnitude is floor(|dividend| / |divisor|) and the remainder magnitude is |dividend| mod |divisor|.
- R2: `op_size` 0, 1, 2 and 3 select widths of 8, 16, 32 and 64 bits. Only the low width bits of each operand are used, read as two's complement, and higher bits have no effect on any output.
- R3: When the dividend and the divisor have the same sign, the quotient and the remainder are both zero or positive.
- R4: When the dividend and the divisor have opposite signs, the quotient and the remainder are both zero or negative.
- R5: Results are truncated to the selected width and sign-extended from that width's top bit to 64 bits.
- R6: The most negative value of a width is divided correctly. Divided by -1 it gives a quotient that wraps to the same most negative value, with a remainder of 0.
- R7: A divisor that is zero in the selected width sets `div_zero`, returns a quotient of 0 and a remainder equal to the sign-extended dividend, and completes without iterating. `done` rises two sampling cycles after the start cycle. `div_zero` is 0 for every other completion.
- R8: A non-zero division raises `done` exactly width+1 clock edges after the edge that accepts `start`. `done` is high for one cycle, `busy` is high from the cycle after acceptance through the last cycle before `done`, and `busy` is low while `done` is high.
- R9: `start` is ignored while `busy` is high. The running operation's results are unchanged and no extra `done` follows.
- R10: After reset, `busy`, `done`, `div_zero`, `quotient` and `remainder` are all 0.
- R11: `quotient`, `remainder` and `div_zero` hold their values after `done` until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request, accepted when not busy |
| op_size | input | 2 | Operand size: 0 byte, 1 halfword, 2 word, 3 long |
| src_val | input | 64 | Dividend (source operand) |
| dst_val | input | 64 | Divisor (destination operand) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Last completed operation had a zero divisor |
| quotient | output | 64 | Signed quotient, sign-extended |
| remainder | output | 64 | Signed remainder with the quotient's sign, sign-extended |

## Verification
The iteration counter sets the length of an operation. A wrong starting count or a wrong exit shows as `done` rising on the wrong cycle, and the fault is visible at the very first completion. A wrong partial remainder or a wrong quotient shift register cannot be seen while `busy` is high. It appears only at `done`, as a wrong quotient or remainder for most operand pairs. A wrong sign flag shows at the same cycle as a quotient and remainder of opposite signs, or with the sign of the dividend instead of the shared sign. The vectors therefore cover all four sign combinations, every size, the most negative values and a zero divisor whose upper bits are non-zero.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_LONG = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } state_e;

  // operand width in bits for a size code
  function automatic int width_of(input logic [1:0] sz);
    return 8 << int'(sz);
  endfunction

endpackage

// File: rtl/sdiv_operand.sv
// Narrows an operand to the selected size, reports its sign and magnitude.
module sdiv_operand #(
  parameter int XLEN = 64
) (
  input  logic [1:0]      sz,
  input  logic [XLEN-1:0] val,
  output logic            neg,
  output logic [XLEN-1:0] mag
);
  import sdiv_pkg::*;

  int              sh;
  logic [XLEN-1:0] shl;
  logic [XLEN-1:0] sx;

  always_comb begin
    sh  = XLEN - width_of(sz);
    shl = val << sh;
    sx  = $signed(shl) >>> sh;
    neg = sx[XLEN-1];
    mag = neg ? (~sx + 1'b1) : sx;
  end
endmodule

// File: rtl/sdiv_core.sv
// Restoring magnitude divider: one quotient bit per step.
// The partial remainder is shifted through a datapath one bit wider than XLEN.
module sdiv_core #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            zero_div,
  input  logic            step,
  input  logic [XLEN-1:0] dvd_aligned,
  input  logic [XLEN-1:0] dvd_mag,
  input  logic [XLEN-1:0] dvs_mag,
  output logic [XLEN-1:0] quo,
  output logic [XLEN:0]   rem
);
  logic [XLEN-1:0] dvs_q;
  logic [XLEN:0]   rem_sh;
  logic [XLEN:0]   diff;
  logic            ge;

  always_comb begin
    rem_sh = {rem[XLEN-1:0], quo[XLEN-1]};
    ge     = rem_sh >= {1'b0, dvs_q};
    diff   = rem_sh - {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quo   <= '0;
      rem   <= '0;
      dvs_q <= '0;
    end else if (load) begin
      dvs_q <= dvs_mag;
      if (zero_div) begin
        quo <= '0;
        rem <= {1'b0, dvd_mag};
      end else begin
        quo <= dvd_aligned;
        rem <= '0;
      end
    end else if (step) begin
      quo <= {quo[XLEN-2:0], ge};
      rem <= ge ? diff : rem_sh;
    end
  end
endmodule

// File: rtl/sdiv_fix.sv
// Applies the shared result sign, truncates to the size and sign-extends.
module sdiv_fix #(
  parameter int XLEN = 64
) (
  input  logic [1:0]      sz,
  input  logic            neg,
  input  logic [XLEN-1:0] quo_mag,
  input  logic [XLEN:0]   rem_mag,
  output logic [XLEN-1:0] quo_out,
  output logic [XLEN-1:0] rem_out
);
  import sdiv_pkg::*;

  int              sh;
  logic [XLEN-1:0] q_s;
  logic [XLEN-1:0] r_s;
  logic [XLEN-1:0] q_l;
  logic [XLEN-1:0] r_l;

  always_comb begin
    sh      = XLEN - width_of(sz);
    q_s     = neg ? (~quo_mag + 1'b1) : quo_mag;
    r_s     = XLEN'(neg ? (~rem_mag + 1'b1) : rem_mag);
    q_l     = q_s << sh;
    r_l     = r_s << sh;
    quo_out = $signed(q_l) >>> sh;
    rem_out = $signed(r_l) >>> sh;
  end
endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      op_size,
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN-1:0] dst_val,
  output logic            busy,
  output logic            done,
  output logic            div_zero,
  output logic [XLEN-1:0] quotient,
  output logic [XLEN-1:0] remainder
);
  import sdiv_pkg::*;

  localparam int CW = $clog2(XLEN);

  state_e          state;
  logic [CW-1:0]   cnt;
  logic [1:0]      sz_q;
  logic            neg_q;
  logic            dz_q;

  logic            dvd_neg, dvs_neg;
  logic [XLEN-1:0] dvd_mag, dvs_mag, dvd_al;
  logic            accept, dvs_zero;
  logic [XLEN-1:0] core_quo;
  logic [XLEN:0]   core_rem;
  logic [XLEN-1:0] fix_quo, fix_rem;

  sdiv_operand #(.XLEN(XLEN)) u_dvd (
    .sz(op_size), .val(src_val), .neg(dvd_neg), .mag(dvd_mag)
  );

  sdiv_operand #(.XLEN(XLEN)) u_dvs (
    .sz(op_size), .val(dst_val), .neg(dvs_neg), .mag(dvs_mag)
  );

  always_comb begin
    accept   = start && (state == ST_IDLE);
    dvs_zero = (dvs_mag == '0);
    dvd_al   = dvd_mag << (XLEN - width_of(op_size));
  end

  sdiv_core #(.XLEN(XLEN)) u_core (
    .clk(clk), .rst(rst),
    .load(accept), .zero_div(dvs_zero), .step(state == ST_RUN),
    .dvd_aligned(dvd_al), .dvd_mag(dvd_mag), .dvs_mag(dvs_mag),
    .quo(core_quo), .rem(core_rem)
  );

  sdiv_fix #(.XLEN(XLEN)) u_fix (
    .sz(sz_q), .neg(neg_q), .quo_mag(core_quo), .rem_mag(core_rem),
    .quo_out(fix_quo), .rem_out(fix_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sz_q      <= '0;
      neg_q     <= 1'b0;
      dz_q      <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      div_zero  <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          sz_q <= op_size;
          busy <= 1'b1;
          dz_q <= dvs_zero;
          if (dvs_zero) begin
            neg_q <= dvd_neg;          // remainder returns the dividend
            state <= ST_FIN;
          end else begin
            neg_q <= dvd_neg ^ dvs_neg;
            cnt   <= CW'(width_of(op_size) - 1);
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (cnt == '0) state <= ST_FIN;
          else           cnt   <= cnt - 1'b1;
        end
        ST_FIN: begin
          busy      <= 1'b0;
          done      <= 1'b1;
          div_zero  <= dz_q;
          quotient  <= fix_quo;
          remainder <= fix_rem;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdiv_unit_chk.sv
module sdiv_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [1:0]      op_size,
  input logic            busy,
  input logic            done,
  input logic            div_zero,
  input logic [XLEN-1:0] quotient,
  input logic [XLEN-1:0] remainder
);
  logic [1:0] sz_l;
  int         lat;

  function automatic logic [XLEN-1:0] ext(input logic [XLEN-1:0] v, input logic [1:0] sz);
    int sh;
    logic [XLEN-1:0] t;
    sh = XLEN - (8 << int'(sz));
    t  = v << sh;
    return $signed(t) >>> sh;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sz_l <= '0;
      lat  <= 0;
    end else if (start && !busy) begin
      sz_l <= op_size;
      lat  <= 0;
    end else if (busy) begin
      lat <= lat + 1;
    end
  end

  p_busy_after_start_r8: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_not_busy_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7 zero divisor completes after one busy cycle; R8 otherwise width+1
  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> lat == (div_zero ? 1 : (8 << int'(sz_l)) + 1));

  p_zero_quotient_r7: assert property (@(posedge clk) disable iff (rst)
    done && div_zero |-> quotient == '0);

  p_shared_sign_r4: assert property (@(posedge clk) disable iff (rst)
    done && quotient != '0 && remainder != '0 |-> quotient[XLEN-1] == remainder[XLEN-1]);

  p_sign_extended_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (quotient == ext(quotient, sz_l)) && (remainder == ext(remainder, sz_l)));
endmodule

bind sdiv_unit sdiv_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op_size(op_size),
  .busy(busy), .done(done), .div_zero(div_zero),
  .quotient(quotient), .remainder(remainder)
);

// File: tb/sdiv_unit_test.sv
module sdiv_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  // {size, dividend, divisor}; expected results come from model()
  localparam logic [129:0] VEC [NV] = '{
    {2'd0, 64'h0000_0000_0000_0064, 64'h0000_0000_0000_0007},  // 100/7
    {2'd0, 64'hABCD_0000_0000_009C, 64'h0000_0000_0000_0007},  // -100/7, junk high bits
    {2'd0, 64'h0000_0000_0000_0064, 64'h0000_0000_0000_00F9},  // 100/-7
    {2'd0, 64'h0000_0000_0000_009C, 64'h0000_0000_1234_00F9},  // -100/-7
    {2'd0, 64'h0000_0000_0000_0080, 64'h0000_0000_0000_00FF},  // -128/-1
    {2'd1, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_0001},  // -32768/1
    {2'd1, 64'h0000_0000_0000_04D2, 64'h0000_0000_0000_FC18},  // 1234/-1000
    {2'd2, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF},  // min/-1
    {2'd2, 64'h0000_0000_FFF0_BDC0, 64'h0000_0000_0000_0003},  // -1000000/3
    {2'd3, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF},  // min/-1
    {2'd3, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0001_0003},
    {2'd3, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0009},  // 5/9
    {2'd1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_FFFB},  // 0/-5
    {2'd3, 64'hFFFF_FFFF_FFFF_FF9C, 64'h0000_0000_0000_0007}   // -100/7
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op_size = '0;
  logic [63:0] src_val = '0;
  logic [63:0] dst_val = '0;
  logic        busy, done, div_zero;
  logic [63:0] quotient, remainder;

  int n_chk = 0;
  int n_bad = 0;

  sdiv_unit uut (
    .clk(clk), .rst(rst), .start(start), .op_size(op_size),
    .src_val(src_val), .dst_val(dst_val), .busy(busy), .done(done),
    .div_zero(div_zero), .quotient(quotient), .remainder(remainder)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural model: signed division on magnitudes, shared result sign
  task automatic model(input logic [1:0] sz, input logic [63:0] a, input logic [63:0] b,
                       output logic [63:0] eq, output logic [63:0] er, output logic ez);
    int sh;
    logic [63:0] ta, tb, tq, tr;
    logic signed [63:0] xa, xb;
    logic signed [64:0] sa, sb, ma, mb, q, r;
    sh = 64 - (8 << int'(sz));
    ta = a << sh; tb = b << sh;
    xa = $signed(ta) >>> sh; xb = $signed(tb) >>> sh;
    sa = xa; sb = xb;
    if (sb == 0) begin
      ez = 1'b1; eq = '0; er = xa;
    end else begin
      ez = 1'b0;
      ma = (sa < 0) ? -sa : sa;
      mb = (sb < 0) ? -sb : sb;
      q = ma / mb; r = ma % mb;
      if ((sa < 0) != (sb < 0)) begin q = -q; r = -r; end
      tq = q[63:0] << sh; tr = r[63:0] << sh;
      eq = $signed(tq) >>> sh; er = $signed(tr) >>> sh;
    end
  endtask

  task automatic launch(input logic [1:0] sz, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    op_size = sz; src_val = a; dst_val = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // cyc is the index of the sampling negedge after the start negedge
  task automatic wait_done(inout int cyc);
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] eq, er, hq, hr;
    logic        ez;
    int          cyc;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy", {63'd0, busy}, 64'd0);
    chk("R10 done", {63'd0, done}, 64'd0);
    chk("R10 div_zero", {63'd0, div_zero}, 64'd0);
    chk("R10 quotient", quotient, 64'd0);
    chk("R10 remainder", remainder, 64'd0);

    // R1 R2 R3 R4 R5 R6: vector walk, with R8 latency and pulse shape
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  sz;
      logic [63:0] a, b;
      {sz, a, b} = VEC[i];
      model(sz, a, b, eq, er, ez);
      launch(sz, a, b);
      chk("R8 busy after accept", {63'd0, busy}, 64'd1);
      cyc = 1;
      wait_done(cyc);
      chk("R8 latency", 64'(cyc), 64'((8 << int'(sz)) + 2));
      chk("R1/R3/R4/R6 quotient", quotient, eq);
      chk("R1/R3/R4/R5 remainder", remainder, er);
      chk("R7 div_zero clear", {63'd0, div_zero}, 64'd0);
      chk("R8 busy low at done", {63'd0, busy}, 64'd0);
      @(negedge clk);
      chk("R8 done one cycle", {63'd0, done}, 64'd0);
    end

    // R7 zero divisor in byte size, upper divisor bits non-zero (R2)
    launch(2'd0, 64'h0000_0000_0000_00F0, 64'h0000_0000_0000_0100);
    cyc = 1;
    wait_done(cyc);
    chk("R7 latency", 64'(cyc), 64'd2);
    chk("R7 flag", {63'd0, div_zero}, 64'd1);
    chk("R7 quotient", quotient, 64'd0);
    chk("R7 remainder", remainder, 64'hFFFF_FFFF_FFFF_FFF0);

    // R11 outputs hold after done
    hq = quotient; hr = remainder;
    repeat (6) @(negedge clk);
    chk("R11 quotient hold", quotient, hq);
    chk("R11 remainder hold", remainder, hr);
    chk("R11 div_zero hold", {63'd0, div_zero}, 64'd1);

    // R7 zero divisor in long size
    launch(2'd3, 64'h0000_0000_0000_0005, 64'h0);
    cyc = 1;
    wait_done(cyc);
    chk("R7 long remainder", remainder, 64'd5);
    chk("R7 long flag", {63'd0, div_zero}, 64'd1);

    // R9 start during busy is ignored
    launch(2'd3, 64'd100, 64'd7);
    op_size = 2'd0; src_val = 64'd1; dst_val = 64'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 2;
    wait_done(cyc);
    chk("R9 latency unchanged", 64'(cyc), 64'd66);
    chk("R9 quotient", quotient, 64'd14);
    chk("R9 remainder", remainder, 64'd2);
    chk("R9 div_zero", {63'd0, div_zero}, 64'd0);
    begin
      int extra = 0;
      for (int k = 0; k < 70; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R9 no extra done", 64'(extra), 64'd0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule